// File: doc/BRIEF.md
# SPI Master Chip-Select Sequencer

This block is an SPI master. It moves 8-bit words over SCK, MOSI and MISO and sequences four active-low chip-select lines around each transfer. Software uses a small register port to set a clock divisor and two delays. Each word it writes carries its own target select. The block then decides whether the active chip select can stay low for the next word or must go high. When it must go high, it waits out a deselect interval before it drives the next select low. A keep option leaves the last select low after the traffic stops. An NSS input lets another master signal contention. If that input goes low while the block is enabled and the check is armed, the block halts, releases the bus and raises a sticky fault flag.

The sequencer is one state machine with five states:
- **IDLE** waits for an enabled, pending word.
- **DESEL** holds every select high for the deselect interval.
- **LEAD** drives the chosen select low and holds SCK low for one half-period.
- **SHIFT** runs the fifteen remaining SCK edges.
- **TRAIL** holds the select low with SCK low for the inter-transfer gap.

The transitions are:
- IDLE→LEAD: a word is pending and no select is held, or the held select is the same one.
- IDLE→DESEL: a held select differs from the new target.
- DESEL→LEAD: the interval has elapsed and a word is pending.
- DESEL→IDLE: the interval has elapsed and nothing is pending.
- LEAD→SHIFT: the lead half-period has elapsed.
- SHIFT→TRAIL: the sixteenth edge has been made.
- TRAIL→LEAD: a word is pending for the same select.
- TRAIL→DESEL: a word is pending for another select, or nothing is pending and keep is off.
- TRAIL→IDLE: nothing is pending and keep is on.
- Any state→IDLE: a mode fault.

Top module: `spi_cs_master`

## Requirements
- R1: After reset the block drives cs_n all high and SCK low. STATUS (address 3) reads 0x000001: bit0 tx_empty=1, bit1 rx_full=0, bit2 fault=0, bit3 enabled=0, rx byte in bits [15:8].
- R2: A transfer sends 8 bits MSB first in SPI mode 0. The half-period H is CFG[7:0]>>1 clock cycles, and a divisor below 2 acts as 2. SCK stays low for H cycles after the select goes low, then makes 16 edges H cycles apart. MISO is sampled on each rising edge. At the end of the transfer the byte appears in STATUS[15:8] and rx_full is set. A STATUS read clears rx_full.
- R3: Writing TXDATA (address 2) queues data [7:0] for select [9:8], which drives cs_n[n] low. From idle, the select goes low after the second clock edge following the write or the enable that releases it.
- R4: After each transfer the select stays low and SCK low for max(CFG[15:8], H) cycles before anything else happens.
- R5: With keep off (CFG[24]=0) and no word pending, all selects go high after the gap and stay high for max(CFG[23:16], H) cycles before any select can go low.
- R6: With keep on, the last select stays low while idle. A new word for the same select starts without a release. A word for another select first drives all selects high for the deselect interval.
- R7: A word pending at the end of the gap for the same select starts at once, and the select stays low between the two transfers.
- R8: tx_empty clears on a TXDATA write and sets when the word moves into the shifter. A write in the same cycle as that move leaves the new word pending.
- R9: If the block is enabled, detection is armed and NSS is low at a clock edge, the block clears enable, sets fault, drives every select high and SCK low on that edge, and abandons the transfer.
- R10: The fault flag stays set until a STATUS read. A read in the same cycle that a fault occurs leaves the flag set.
- R11: CTRL (address 0) bit0 enables the block and bit1 disables it. While the block is disabled no transfer starts, and a pending word is kept with tx_empty=0.
- R12: CFG[25]=1 turns fault detection off. A low NSS while the block is disabled has no effect either.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a STATUS read clears the flags) |
| reg_addr | input | 2 | Register address: 0 CTRL, 1 CFG, 2 TXDATA, 3 STATUS |
| reg_wdata | input | 26 | Write data |
| reg_rdata | output | 26 | Read data (CFG or STATUS, otherwise 0) |
| nss_in | input | 1 | Contention input from another master, active low |
| miso | input | 1 | Serial data in |
| sck | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | CS_COUNT | Active-low chip selects |

## Verification
Two pairs of events can land on the same clock edge. In the first, a TXDATA write coincides with the edge that moves the previous word into the shifter. The bench provokes this by writing a second word in the cycle between the first write and its LEAD. It judges the outcome by a second transfer that follows the gap with no release. In the second, a STATUS read coincides with a fault that aborts a transfer in its LEAD state. The bench checks that the read returns the pre-fault status, that the flag stays set for the next read and that it clears only on the read after that.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESEL,
        ST_LEAD,
        ST_SHIFT,
        ST_TRAIL
    } seq_state_t;

    localparam int REG_W  = 26;
    localparam int BYTE_W = 8;
    localparam int FLD_W  = 8;

    localparam logic [1:0] A_CTRL = 2'd0;
    localparam logic [1:0] A_CFG  = 2'd1;
    localparam logic [1:0] A_TXD  = 2'd2;
    localparam logic [1:0] A_STAT = 2'd3;

    localparam int CF_GAP_LSB = 8;
    localparam int CF_SEL_LSB = 16;
    localparam int CF_KEEP    = 24;
    localparam int CF_FOFF    = 25;
    localparam int TX_SEL_LSB = 8;

endpackage

// File: rtl/spi_cs_delay.sv
module spi_cs_delay #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] len,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= len - W'(1);
        else if (cnt != '0)
            cnt <= cnt - W'(1);
    end

    assign expired = (cnt == '0);

    // R4: every timed interval lasts at least one cycle
    a_r4_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (len != '0));

endmodule

// File: rtl/spi_cs_shifter.sv
module spi_cs_shifter #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          sample,
    input  logic          shift,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx
);
    logic [DW-1:0] tx_sh;
    logic [DW-1:0] rx_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sh <= '0;
            rx_sh <= '0;
        end else begin
            if (load)
                tx_sh <= din;
            else if (shift)
                tx_sh <= {tx_sh[DW-2:0], 1'b0};
            if (sample)
                rx_sh <= {rx_sh[DW-2:0], miso};
        end
    end

    assign mosi = tx_sh[DW-1];
    assign rx   = rx_sh;

    // R2: a rising edge never coincides with a falling edge
    a_r2_edge_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sample && shift));

endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int CS_COUNT = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_wr,
    input  logic                reg_rd,
    input  logic [1:0]          reg_addr,
    input  logic [REG_W-1:0]    reg_wdata,
    output logic [REG_W-1:0]    reg_rdata,
    input  logic                nss_in,
    input  logic                miso,
    output logic                sck,
    output logic                mosi,
    output logic [CS_COUNT-1:0] cs_n
);
    localparam int SEL_W  = (CS_COUNT > 1) ? $clog2(CS_COUNT) : 1;
    localparam int EDGES  = 2 * BYTE_W;
    localparam int EDGE_W = $clog2(EDGES);

    seq_state_t state, state_n;

    logic              enabled, fault, rx_full, tx_full, cs_on, sck_q;
    logic [FLD_W-1:0]  cfg_div, cfg_gap, cfg_sel;
    logic              cfg_keep, cfg_foff;
    logic [BYTE_W-1:0] hold_data, rx_data, rx_byte;
    logic [SEL_W-1:0]  hold_sel, cur_sel;
    logic [EDGE_W-1:0] ecnt;
    logic [FLD_W-1:0]  half, gap_len, sel_len, ld_val;
    logic              ld, expired, load_shift, rise, fall, done_byte, cs_set, cs_clr;
    logic              wr_ctrl, wr_cfg, wr_tx, stat_rd, fault_hit, start_ok, last_edge;

    assign wr_ctrl   = reg_wr && (reg_addr == A_CTRL);
    assign wr_cfg    = reg_wr && (reg_addr == A_CFG);
    assign wr_tx     = reg_wr && (reg_addr == A_TXD);
    assign stat_rd   = reg_rd && (reg_addr == A_STAT);
    assign fault_hit = enabled && !cfg_foff && !nss_in;
    assign start_ok  = enabled && tx_full;
    assign last_edge = (ecnt == EDGE_W'(EDGES - 1));

    always_comb begin
        half    = (cfg_div < FLD_W'(2)) ? FLD_W'(1) : (cfg_div >> 1);
        gap_len = (cfg_gap < half) ? half : cfg_gap;
        sel_len = (cfg_sel < half) ? half : cfg_sel;
    end

    spi_cs_delay #(.W(FLD_W)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(ld), .len(ld_val), .expired(expired)
    );

    spi_cs_shifter #(.DW(BYTE_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .load(load_shift), .din(hold_data),
        .sample(rise), .shift(fall), .miso(miso), .mosi(mosi), .rx(rx_byte)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // next state and sequencing strobes
    always_comb begin
        state_n    = state;
        ld         = 1'b0;
        ld_val     = half;
        load_shift = 1'b0;
        rise       = 1'b0;
        fall       = 1'b0;
        done_byte  = 1'b0;
        cs_set     = 1'b0;
        cs_clr     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start_ok) begin
                    if (cs_on && (cur_sel != hold_sel)) begin
                        state_n = ST_DESEL; cs_clr = 1'b1; ld = 1'b1; ld_val = sel_len;
                    end else begin
                        state_n = ST_LEAD; ld = 1'b1; load_shift = 1'b1; cs_set = 1'b1;
                    end
                end
            end
            ST_DESEL: begin
                if (expired) begin
                    if (start_ok) begin
                        state_n = ST_LEAD; ld = 1'b1; load_shift = 1'b1; cs_set = 1'b1;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            ST_LEAD: begin
                if (expired) begin
                    state_n = ST_SHIFT; ld = 1'b1; rise = 1'b1;
                end
            end
            ST_SHIFT: begin
                if (expired) begin
                    ld = 1'b1;
                    if (sck_q) fall = 1'b1;
                    else       rise = 1'b1;
                    if (last_edge) begin
                        done_byte = 1'b1; state_n = ST_TRAIL; ld_val = gap_len;
                    end
                end
            end
            ST_TRAIL: begin
                if (expired) begin
                    if (start_ok && (hold_sel == cur_sel)) begin
                        state_n = ST_LEAD; ld = 1'b1; load_shift = 1'b1; cs_set = 1'b1;
                    end else if (start_ok || !cfg_keep) begin
                        state_n = ST_DESEL; cs_clr = 1'b1; ld = 1'b1; ld_val = sel_len;
                    end else begin
                        state_n = ST_IDLE;
                    end
                end
            end
            default: state_n = ST_IDLE;
        endcase
        if (fault_hit) begin
            state_n    = ST_IDLE;
            ld         = 1'b0;
            load_shift = 1'b0;
            rise       = 1'b0;
            fall       = 1'b0;
            done_byte  = 1'b0;
            cs_set     = 1'b0;
            cs_clr     = 1'b1;
        end
    end

    // registered outputs and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enabled <= 1'b0;  fault <= 1'b0;   rx_full <= 1'b0;  tx_full <= 1'b0;
            cs_on   <= 1'b0;  sck_q <= 1'b0;   cur_sel <= '0;    hold_sel <= '0;
            hold_data <= '0;  rx_data <= '0;   ecnt <= '0;
            cfg_div <= '0;    cfg_gap <= '0;   cfg_sel <= '0;
            cfg_keep <= 1'b0; cfg_foff <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                if (reg_wdata[1])      enabled <= 1'b0;
                else if (reg_wdata[0]) enabled <= 1'b1;
            end
            if (fault_hit) enabled <= 1'b0;

            if (fault_hit)    fault <= 1'b1;
            else if (stat_rd) fault <= 1'b0;

            if (done_byte)    rx_full <= 1'b1;
            else if (stat_rd) rx_full <= 1'b0;
            if (done_byte)    rx_data <= rx_byte;

            if (wr_tx)           tx_full <= 1'b1;
            else if (load_shift) tx_full <= 1'b0;
            if (wr_tx) begin
                hold_data <= reg_wdata[BYTE_W-1:0];
                hold_sel  <= reg_wdata[TX_SEL_LSB +: SEL_W];
            end

            if (cs_clr)      cs_on <= 1'b0;
            else if (cs_set) cs_on <= 1'b1;
            if (cs_set)      cur_sel <= hold_sel;

            if (fault_hit) sck_q <= 1'b0;
            else if (rise) sck_q <= 1'b1;
            else if (fall) sck_q <= 1'b0;

            if (load_shift)       ecnt <= '0;
            else if (rise || fall) ecnt <= ecnt + EDGE_W'(1);

            if (wr_cfg) begin
                cfg_div  <= reg_wdata[FLD_W-1:0];
                cfg_gap  <= reg_wdata[CF_GAP_LSB +: FLD_W];
                cfg_sel  <= reg_wdata[CF_SEL_LSB +: FLD_W];
                cfg_keep <= reg_wdata[CF_KEEP];
                cfg_foff <= reg_wdata[CF_FOFF];
            end
        end
    end

    for (genvar g = 0; g < CS_COUNT; g++) begin : g_cs
        assign cs_n[g] = !(cs_on && (cur_sel == SEL_W'(g)));
    end

    assign sck = sck_q;

    always_comb begin
        unique case (reg_addr)
            A_CFG:   reg_rdata = {cfg_foff, cfg_keep, cfg_sel, cfg_gap, cfg_div};
            A_STAT:  reg_rdata = REG_W'({rx_data, 4'b0000, enabled, fault, rx_full, !tx_full});
            default: reg_rdata = '0;
        endcase
    end

    // R9: a fault releases the bus and halts on the same edge
    a_r9_fault_release: assert property (@(posedge clk) disable iff (!rst_n)
        fault_hit |=> (cs_n == '1 && !sck && !enabled && fault));

    // R10: the fault flag clears only through a status read
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !stat_rd) |=> fault);

    // R4: SCK idles low outside the shifting state
    a_r4_sck_low_outside: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_SHIFT) |-> !sck);

    // R5: every select is high during the deselect interval
    a_r5_desel_high: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DESEL) |-> (cs_n == '1));

    // R7: the select does not move while bits are shifting
    a_r7_cs_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT && !fault_hit) |=> $stable(cs_n));

    // R11: a disabled block never leaves idle for a transfer
    a_r11_halt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !enabled) |=> (state == ST_IDLE));

    // R8: moving a word into the shifter empties the holding register
    a_r8_load_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (load_shift && !wr_tx) |=> !tx_full);

endmodule

// File: tb/spi_cs_master_tb.sv
`timescale 1ns/1ps
module spi_cs_master_tb;
    import spi_cs_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             reg_wr = 1'b0, reg_rd = 1'b0;
    logic [1:0]       reg_addr = 2'd0;
    logic [REG_W-1:0] reg_wdata = '0;
    logic [REG_W-1:0] reg_rdata;
    logic             nss_in = 1'b1, miso = 1'b0;
    logic             sck, mosi;
    logic [3:0]       cs_n;

    int    n_cmp = 0, n_bad = 0;
    string req = "R1";
    logic [3:0] ecs = 4'hF;
    logic       esck = 1'b0;
    bit         finished = 0;

    always #5 clk = ~clk;

    spi_cs_master #(.CS_COUNT(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .nss_in(nss_in), .miso(miso), .sck(sck), .mosi(mosi), .cs_n(cs_n)
    );

    // one clock of the reference model: pins compared against expectation
    task automatic cyc();
        @(negedge clk);
        n_cmp++;
        if (cs_n !== ecs || sck !== esck) begin
            n_bad++;
            $display("FAIL %s: cs_n=%h sck=%b, expected cs_n=%h sck=%b at %0t",
                     req, cs_n, sck, ecs, esck, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [REG_W-1:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic chk_stat(input logic [REG_W-1:0] exp, input string r);
        reg_addr = A_STAT; reg_rd = 1'b1;
        #1;
        n_cmp++;
        if (reg_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s: status=%h, expected %h", r, reg_rdata, exp);
        end
        cyc();
        reg_rd = 1'b0;
    endtask

    task automatic idle(input int n);
        esck = 1'b0;
        repeat (n) cyc();
    endtask

    function automatic logic [REG_W-1:0] cfg(input int dv, input int gp, input int sl,
                                             input bit keep, input bit foff);
        return {foff, keep, sl[7:0], gp[7:0], dv[7:0]};
    endfunction

    // expected waveform of one frame: lead half, 15 halves, then the gap
    task automatic do_xfer(input int s, input logic [7:0] tx, input logic [7:0] rx,
                           input int h, input int lg);
        logic [7:0] cap;
        cap  = '0;
        ecs  = ~(4'b0001 << s);
        miso = rx[7];
        for (int p = 0; p < 16; p++) begin
            esck = p[0];
            if (p > 0 && !p[0]) miso = rx[7 - p/2];
            for (int k = 0; k < h; k++) begin
                cyc();
                reg_wr = 1'b0;
                if (p[0] && k == 0) cap = {cap[6:0], mosi};
            end
        end
        esck = 1'b0;
        repeat (lg) cyc();
        n_cmp++;
        if (cap !== tx) begin
            n_bad++;
            $display("FAIL R2: mosi byte=%h, expected %h", cap, tx);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        req = "R1"; cyc();
        chk_stat(26'h1, "R1");

        // R3, R5: single transfer, select 1, release after gap
        req = "R5";
        wr(A_CFG, cfg(4, 0, 5, 0, 0));
        wr(A_CTRL, 26'h1);
        idle(2);
        req = "R3";
        wr(A_TXD, 26'h1A5);
        do_xfer(1, 8'hA5, 8'h3C, 2, 2);
        req = "R5"; ecs = 4'hF; idle(7);
        chk_stat(26'h3C0B, "R2");
        chk_stat(26'h3C09, "R2");

        // R7, R8: second word written on the load edge, same target
        wr(A_CFG, cfg(4, 6, 3, 0, 0));
        wr(A_TXD, 26'h281);
        reg_addr = A_TXD; reg_wdata = 26'h27E; reg_wr = 1'b1;
        req = "R4 R8"; do_xfer(2, 8'h81, 8'h11, 2, 6);
        req = "R7";    do_xfer(2, 8'h7E, 8'hE7, 2, 6);
        ecs = 4'hF; idle(3);
        chk_stat(26'hE70B, "R2");

        // R6: keep select, reuse, then switch target through deselect
        req = "R6";
        wr(A_CFG, cfg(6, 0, 4, 1, 0));
        wr(A_TXD, 26'h0C3);
        do_xfer(0, 8'hC3, 8'h5A, 3, 3);
        ecs = 4'hE; idle(4);
        wr(A_TXD, 26'h024);
        do_xfer(0, 8'h24, 8'h99, 3, 3);
        ecs = 4'hE; idle(2);
        wr(A_TXD, 26'h355);
        ecs = 4'hF; idle(4);
        do_xfer(3, 8'h55, 8'hAA, 3, 3);
        ecs = 4'h7; idle(3);

        // R9, R10: fault while a select is held
        req = "R9"; nss_in = 1'b0; ecs = 4'hF; cyc(); nss_in = 1'b1;
        req = "R10"; idle(3);
        chk_stat(26'hAA07, "R10");
        chk_stat(26'hAA01, "R10");

        // R11: halted, pending word kept
        req = "R11";
        wr(A_TXD, 26'h10F);
        idle(6);
        chk_stat(26'hAA00, "R11");
        wr(A_CTRL, 26'h1);
        ecs = 4'hD; cyc();
        // R10: status read on the same edge as a fault in LEAD
        req = "R10";
        nss_in = 1'b0; reg_addr = A_STAT; reg_rd = 1'b1;
        #1;
        n_cmp++;
        if (reg_rdata !== 26'hAA09) begin
            n_bad++;
            $display("FAIL R10: status=%h, expected %h", reg_rdata, 26'hAA09);
        end
        ecs = 4'hF; cyc();
        nss_in = 1'b1; reg_rd = 1'b0;
        chk_stat(26'hAA05, "R10");
        chk_stat(26'hAA01, "R10");

        // R12: detection off, then disabled block ignores NSS
        req = "R12";
        wr(A_CFG, cfg(4, 0, 0, 0, 1));
        wr(A_CTRL, 26'h1);
        nss_in = 1'b0; idle(3);
        chk_stat(26'hAA09, "R12");
        nss_in = 1'b1;
        wr(A_CTRL, 26'h2);
        wr(A_CFG, cfg(4, 0, 0, 0, 0));
        nss_in = 1'b0; idle(2); nss_in = 1'b1;
        chk_stat(26'hAA01, "R12");

        // R2: divisor below 2 clamps to one-cycle half-period
        req = "R2";
        wr(A_CFG, cfg(1, 0, 0, 0, 0));
        wr(A_CTRL, 26'h1);
        wr(A_TXD, 26'h2F0);
        do_xfer(2, 8'hF0, 8'h0F, 1, 1);
        ecs = 4'hF; idle(3);
        chk_stat(26'h0F0B, "R2");

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule